// File: doc/BRIEF.md
# Duty Ramp Sequencer

This block produces breathing and blinking light patterns. It walks a 9-bit duty value through a 64-entry table, starting at one of two programmable bounds and moving toward the other. The current duty value goes to a separate PWM generator. Time comes from an external 1 kHz tick. Each table position is held for a step time, which is chosen by a 4-bit code from a fixed non-linear set of millisecond values.

When the walk reaches the end it is travelling toward, the block can hold that entry for an extra pause. The pause is a whole number of step times, chosen by a 6-bit code from a second fixed table, and each end has its own pause enable and code. After any pause the walk does one of two things. In wrap mode it jumps back to the starting bound. In ping-pong mode it turns around. The sequence can repeat forever, or it can stop after one pass, keep its last value and raise a done flag.

The table is loaded through two byte-wide write registers. The same port can also read any entry back.

Top module: `duty_ramp_seq`

## Requirements
- R1: While reset is low, `duty`, `cur_idx`, `busy`, `done` and `rd_valid` are all zero.
- R2: The table port works as follows:
  - A write to the low register stores duty bits 7:0 in a staging byte.
  - A write to the high register stores an entry when its bit 6 is 0. Bit 7 of the high register is duty bit 8, and bits 5:0 are the entry index. The entry takes the staged byte as its low bits.
  - When bit 6 of the high register is 1, the write is a read request and changes no entry. In the next cycle `rd_valid` is 1 for one cycle and `rd_data` holds the addressed entry.
- R3: When `start` is high and `gen_en` is high, the sequence restarts on the next clock edge from any state.
  - The starting index is `lo_idx` when `ramp_up` is 1, and `hi_idx` otherwise.
  - `duty` takes that entry's value and `busy` goes high.
- R4: Each table position is held for N ticks of `ms_tick`. N comes from `step_code` values 0 to 15, which map in order to 0, 1, 2, 3, 4, 6, 8, 16, 18, 24, 32, 36, 64, 128, 256 and 512. The index changes only after a tick.
- R5: While running, the index moves by +1 when travelling up and by -1 when travelling down, and stays within [`lo_idx`, `hi_idx`]. This assumes `lo_idx` <= `hi_idx`.
- R6: With `bounce_en` at 0, a step that ends at the bound being approached (`hi_idx` going up, `lo_idx` going down) is followed by a return to the starting bound if `loop_en` is 1. Otherwise the block goes to done.
- R7: With `bounce_en` at 1:
  - Reaching the far bound reverses the direction and moves one index back. If `lo_idx` equals `hi_idx`, the index stays.
  - Reaching the starting bound again reverses the direction when `loop_en` is 1. Otherwise the block goes to done.
- R8: When the end that is reached has its pause enabled, that entry is held for an extra P x N ticks. `hold_hi_*` applies at `hi_idx` while travelling up, and `hold_lo_*` at `lo_idx` while travelling down. P comes from the 6-bit code:
  - codes 0 to 15 give 1 to 16;
  - codes 16 to 35 give 23, 28, 31, 42, 47, 56, 63, 83, 94, 111, 125, 167, 188, 222, 250, 333, 375, 500, 667, 750;
  - codes 36 to 44 give 800 to 1600 in steps of 100;
  - codes 45 and 46 give 1800 and 2000;
  - codes 47 to 56 give 2500 to 7000 in steps of 500;
  - codes above 56 give 7000.
- R9: In done, `done` is 1, `busy` is 0, and `cur_idx` and `duty` hold their last values until the next start or until `gen_en` falls.
- R10: A `step_code` of 0 freezes the index while running, and done is never reached.
- R11: With `gen_en` low, the block goes idle on the next edge: `busy`, `done` and `duty` are 0, and `start` is ignored.
- R12: While busy or done, `duty` always equals the table entry at `cur_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| gen_en | input | 1 | Sequencer enable; low forces idle |
| start | input | 1 | Start strobe |
| ramp_up | input | 1 | 1: start at lo_idx and count up; 0: start at hi_idx and count down |
| bounce_en | input | 1 | Ping-pong at the ends instead of wrapping |
| loop_en | input | 1 | Repeat without end |
| step_code | input | 4 | Step time code |
| lo_idx | input | 6 | Lower table bound |
| hi_idx | input | 6 | Upper table bound |
| hold_hi_en | input | 1 | Pause enable at the upper bound |
| hold_hi_code | input | 6 | Pause code at the upper bound |
| hold_lo_en | input | 1 | Pause enable at the lower bound |
| hold_lo_code | input | 6 | Pause code at the lower bound |
| tw_lo_wr | input | 1 | Write strobe, low table register |
| tw_lo_data | input | 8 | Duty bits 7:0 |
| tw_hi_wr | input | 1 | Write strobe, high table register (commit or read) |
| tw_hi_data | input | 8 | [7] duty bit 8, [6] read request, [5:0] index |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 9 | Table entry read back |
| duty | output | 9 | Current duty value to the PWM generator |
| cur_idx | output | 6 | Current table index |
| busy | output | 1 | Sequence running or pausing |
| done | output | 1 | One-shot sequence finished |

## Verification
The walk is tried over a grid of three bound pairs, the first three step codes, both directions, wrap and ping-pong, one pass and repeat, and pauses on and off. The pairs are a span, a short span and a single entry. Each run is compared cycle by cycle with an arithmetically built position trace. This grid separates increment from decrement, wrap from turn-around, which end a pause belongs to, and where a one-shot run stops. Two further sweeps measure the time from start to done. One covers every step code with a two-entry range. The other covers every pause code with a single entry, and together they check both timing tables entry by entry. Separate cases cover the following:
- readback of all 64 entries;
- a read request that must not write;
- a zero step code;
- disabling the block mid-run;
- a start from done.

// File: rtl/duty_ramp_seq.sv
module duty_ramp_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       gen_en,
  input  logic       start,
  input  logic       ramp_up,
  input  logic       bounce_en,
  input  logic       loop_en,
  input  logic [3:0] step_code,
  input  logic [5:0] lo_idx,
  input  logic [5:0] hi_idx,
  input  logic       hold_hi_en,
  input  logic [5:0] hold_hi_code,
  input  logic       hold_lo_en,
  input  logic [5:0] hold_lo_code,
  input  logic       tw_lo_wr,
  input  logic [7:0] tw_lo_data,
  input  logic       tw_hi_wr,
  input  logic [7:0] tw_hi_data,
  output logic       rd_valid,
  output logic [8:0] rd_data,
  output logic [8:0] duty,
  output logic [5:0] cur_idx,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD, ST_DONE} st_t;

  st_t        st;
  logic [8:0] tbl [64];
  logic [7:0] low_stage;
  logic [5:0] idx_q;
  logic [8:0] duty_q;
  logic       dir_q, start_dir_q;
  logic [9:0] ms_cnt;
  logic [12:0] p_cnt;

  function automatic logic [9:0] step_ms(input logic [3:0] c);
    case (c)
      4'd0:  return 10'd0;
      4'd1:  return 10'd1;
      4'd2:  return 10'd2;
      4'd3:  return 10'd3;
      4'd4:  return 10'd4;
      4'd5:  return 10'd6;
      4'd6:  return 10'd8;
      4'd7:  return 10'd16;
      4'd8:  return 10'd18;
      4'd9:  return 10'd24;
      4'd10: return 10'd32;
      4'd11: return 10'd36;
      4'd12: return 10'd64;
      4'd13: return 10'd128;
      4'd14: return 10'd256;
      default: return 10'd512;
    endcase
  endfunction

  function automatic logic [12:0] pause_len(input logic [5:0] c);
    logic [5:0] k;
    k = (c > 6'd56) ? 6'd56 : c;
    if (k < 6'd16)       return 13'(k) + 13'd1;
    else if (k >= 6'd47) return 13'd2500 + 13'(k - 6'd47) * 13'd500;
    else if (k == 6'd46) return 13'd2000;
    else if (k == 6'd45) return 13'd1800;
    else if (k >= 6'd36) return 13'd800 + 13'(k - 6'd36) * 13'd100;
    else begin
      case (k)
        6'd16: return 13'd23;
        6'd17: return 13'd28;
        6'd18: return 13'd31;
        6'd19: return 13'd42;
        6'd20: return 13'd47;
        6'd21: return 13'd56;
        6'd22: return 13'd63;
        6'd23: return 13'd83;
        6'd24: return 13'd94;
        6'd25: return 13'd111;
        6'd26: return 13'd125;
        6'd27: return 13'd167;
        6'd28: return 13'd188;
        6'd29: return 13'd222;
        6'd30: return 13'd250;
        6'd31: return 13'd333;
        6'd32: return 13'd375;
        6'd33: return 13'd500;
        6'd34: return 13'd667;
        default: return 13'd750;
      endcase
    end
  endfunction

  wire [9:0]  step_len  = step_ms(step_code);
  wire        step_tick = ms_tick && (step_len != 10'd0) && (ms_cnt >= step_len - 10'd1);
  wire        active    = (st == ST_RUN) || (st == ST_HOLD);
  wire        at_end    = dir_q ? (idx_q == hi_idx) : (idx_q == lo_idx);
  wire        hold_en   = dir_q ? hold_hi_en : hold_lo_en;
  wire [12:0] hold_len  = pause_len(dir_q ? hold_hi_code : hold_lo_code);
  wire        end_step  = (st == ST_RUN) && step_tick && at_end;
  wire        advance   = (st == ST_RUN) && step_tick && !at_end;
  wire        hold_last = (st == ST_HOLD) && step_tick && (p_cnt >= hold_len - 13'd1);
  wire        turn      = (end_step && !hold_en) || hold_last;
  wire        finish    = !loop_en && (!bounce_en || (dir_q != start_dir_q));
  wire [5:0]  step_idx  = dir_q ? idx_q + 6'd1 : idx_q - 6'd1;
  wire [5:0]  flip_idx  = (lo_idx == hi_idx) ? idx_q : (dir_q ? idx_q - 6'd1 : idx_q + 6'd1);
  wire [5:0]  turn_idx  = bounce_en ? flip_idx : (start_dir_q ? lo_idx : hi_idx);
  wire [5:0]  first_idx = ramp_up ? lo_idx : hi_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      idx_q <= '0;
      duty_q <= '0;
      dir_q <= 1'b0;
      start_dir_q <= 1'b0;
      ms_cnt <= '0;
      p_cnt <= '0;
    end else if (!gen_en) begin
      st <= ST_IDLE;
      idx_q <= '0;
      duty_q <= '0;
      ms_cnt <= '0;
      p_cnt <= '0;
    end else if (start) begin
      st <= ST_RUN;
      idx_q <= first_idx;
      duty_q <= tbl[first_idx];
      dir_q <= ramp_up;
      start_dir_q <= ramp_up;
      ms_cnt <= '0;
      p_cnt <= '0;
    end else if (active) begin
      if (step_tick) ms_cnt <= '0;
      else if (ms_tick && step_len != 10'd0) ms_cnt <= ms_cnt + 10'd1;
      if (advance) begin
        idx_q <= step_idx;
        duty_q <= tbl[step_idx];
      end
      if (end_step && hold_en) begin
        st <= ST_HOLD;
        p_cnt <= '0;
      end
      if (st == ST_HOLD && step_tick && !hold_last) p_cnt <= p_cnt + 13'd1;
      if (turn) begin
        if (finish) st <= ST_DONE;
        else begin
          st <= ST_RUN;
          idx_q <= turn_idx;
          duty_q <= tbl[turn_idx];
          dir_q <= bounce_en ? !dir_q : dir_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tw_lo_wr) low_stage <= tw_lo_data;
    if (tw_hi_wr && !tw_hi_data[6]) tbl[tw_hi_data[5:0]] <= {tw_hi_data[7], low_stage};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_valid <= tw_hi_wr && tw_hi_data[6];
      if (tw_hi_wr && tw_hi_data[6]) rd_data <= tbl[tw_hi_data[5:0]];
    end
  end

  assign duty    = duty_q;
  assign cur_idx = idx_q;
  assign busy    = active;
  assign done    = (st == ST_DONE);

  // R5
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_idx >= lo_idx && cur_idx <= hi_idx));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(duty) && $stable(cur_idx)));

  // R9
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R11
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!busy && !done && duty == 9'd0));

  // R10
  zero_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy && step_code == 4'd0 && !start && gen_en) |-> $stable(cur_idx));

  // R4
  move_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy && !start && gen_en) && cur_idx != $past(cur_idx)) |-> $past(ms_tick));
endmodule

// File: tb/test_duty_ramp_seq.sv
module test_duty_ramp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TR = 120;
  localparam int WATCHDOG = 195000;

  logic clk = 0, rst_n = 0, ms_tick = 0, gen_en = 0, start = 0;
  logic ramp_up = 0, bounce_en = 0, loop_en = 0;
  logic [3:0] step_code = 0;
  logic [5:0] lo_idx = 0, hi_idx = 0, hold_hi_code = 0, hold_lo_code = 0;
  logic hold_hi_en = 0, hold_lo_en = 0, tw_lo_wr = 0, tw_hi_wr = 0;
  logic [7:0] tw_lo_data = 0, tw_hi_data = 0;
  logic rd_valid, busy, done;
  logic [8:0] rd_data, duty;
  logic [5:0] cur_idx;

  int n_chk = 0, n_fail = 0;
  logic [8:0] tbl_m [64];
  int e_idx [TR];
  bit e_done [TR];

  always #(CLK_PERIOD / 2) clk = ~clk;

  duty_ramp_seq i_duty_ramp_seq (
    .clk, .rst_n, .ms_tick, .gen_en, .start, .ramp_up, .bounce_en, .loop_en,
    .step_code, .lo_idx, .hi_idx, .hold_hi_en, .hold_hi_code, .hold_lo_en,
    .hold_lo_code, .tw_lo_wr, .tw_lo_data, .tw_hi_wr, .tw_hi_data,
    .rd_valid, .rd_data, .duty, .cur_idx, .busy, .done);

  function automatic int step_ref(int c);
    int t [16] = '{0, 1, 2, 3, 4, 6, 8, 16, 18, 24, 32, 36, 64, 128, 256, 512};
    return t[c];
  endfunction

  function automatic int pause_ref(int c);
    int mid [20] = '{23, 28, 31, 42, 47, 56, 63, 83, 94, 111,
                     125, 167, 188, 222, 250, 333, 375, 500, 667, 750};
    int k = (c > 56) ? 56 : c;
    if (k <= 15) return k + 1;
    if (k <= 35) return mid[k - 16];
    if (k <= 44) return 800 + 100 * (k - 36);
    if (k == 45) return 1800;
    if (k == 46) return 2000;
    return 2500 + 500 * (k - 47);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr_entry(input int i, input logic [8:0] v);
    @(negedge clk); tw_lo_wr = 1; tw_lo_data = v[7:0];
    @(negedge clk); tw_lo_wr = 0; tw_hi_wr = 1; tw_hi_data = {v[8], 1'b0, 6'(i)};
    @(negedge clk); tw_hi_wr = 0;
  endtask

  task automatic rd_entry(input int i, output logic v, output logic [8:0] d);
    @(negedge clk); tw_hi_wr = 1; tw_hi_data = {1'b0, 1'b1, 6'(i)};
    @(negedge clk); tw_hi_wr = 0; v = rd_valid; d = rd_data;
  endtask

  task automatic configure(input int lo, input int hi, input int sc, input bit up,
                           input bit bn, input bit lp, input bit he, input int hc,
                           input bit le, input int lc);
    @(negedge clk); gen_en = 0;
    @(negedge clk);
    lo_idx = 6'(lo); hi_idx = 6'(hi); step_code = 4'(sc); ramp_up = up;
    bounce_en = bn; loop_en = lp; hold_hi_en = he; hold_hi_code = 6'(hc);
    hold_lo_en = le; hold_lo_code = 6'(lc); gen_en = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run_seq(input int lo, input int hi, input int sc, input bit up,
                         input bit bn, input bit lp, input bit he, input bit le);
    int s, ph, pl, pos, cur, dur, bad_c, act, exp;
    bit d, sd, fin, far, ae;
    s = step_ref(sc); ph = he ? pause_ref(2) : 0; pl = le ? pause_ref(1) : 0;
    pos = 0; cur = up ? lo : hi; d = up; sd = up; fin = 0;
    while (pos < TR && !fin) begin
      ae = d ? (cur == hi) : (cur == lo);
      dur = ae ? s * (1 + (d ? ph : pl)) : s;
      for (int k = 0; k < dur; k++)
        if (pos < TR) begin e_idx[pos] = cur; e_done[pos] = 0; pos++; end
      if (!ae) cur = d ? cur + 1 : cur - 1;
      else if (bn) begin
        far = (d == sd);
        if (!far && !lp) fin = 1;
        else begin d = !d; if (lo != hi) cur = d ? cur + 1 : cur - 1; end
      end else begin
        if (!lp) fin = 1; else cur = sd ? lo : hi;
      end
    end
    for (int k = pos; k < TR; k++) begin e_idx[k] = cur; e_done[k] = 1; end
    configure(lo, hi, sc, up, bn, lp, he, 2, le, 1);
    bad_c = -1; act = 0; exp = 0;
    for (int c = 0; c < TR; c++) begin
      if (bad_c < 0 && !(cur_idx == 6'(e_idx[c]) && done == e_done[c] &&
          busy == !e_done[c] && duty == tbl_m[e_idx[c]])) begin
        bad_c = c; act = cur_idx; exp = e_idx[c];
      end
      @(negedge clk);
    end
    chk(bad_c < 0, $sformatf("R3 R5 R6 R7 R8 R9 R12 trace lo=%0d hi=%0d sc=%0d up=%0d bn=%0d lp=%0d he=%0d le=%0d cycle=%0d idx",
        lo, hi, sc, up, bn, lp, he, le, bad_c), act, exp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic v;
    logic [8:0] d;
    int c, pairs_lo [3], pairs_hi [3];
    pairs_lo = '{2, 10, 7}; pairs_hi = '{6, 13, 7};

    repeat (3) @(negedge clk);
    chk(duty == 0 && cur_idx == 0 && !busy && !done && !rd_valid, "R1 reset state", {duty, cur_idx, busy, done, rd_valid}, 0);
    rst_n = 1;
    ms_tick = 1;

    for (int i = 0; i < 64; i++) begin
      tbl_m[i] = 9'((i * 73 + 11) % 512);
      wr_entry(i, tbl_m[i]);
    end
    for (int i = 0; i < 64; i++) begin
      rd_entry(i, v, d);
      chk(v && d == tbl_m[i], $sformatf("R2 readback entry %0d", i), d, tbl_m[i]);
      if (i == 0) begin
        @(negedge clk);
        chk(!rd_valid, "R2 rd_valid one cycle", rd_valid, 0);
      end
    end
    @(negedge clk); tw_lo_wr = 1; tw_lo_data = 8'hFF;
    @(negedge clk); tw_lo_wr = 0; tw_hi_wr = 1; tw_hi_data = {1'b1, 1'b1, 6'd9};
    @(negedge clk); tw_hi_wr = 0;
    rd_entry(9, v, d);
    chk(v && d == tbl_m[9], "R2 read request does not write", d, tbl_m[9]);

    for (int p = 0; p < 3; p++)
      for (int sc = 1; sc <= 3; sc++)
        for (int m = 0; m < 16; m++)
          run_seq(pairs_lo[p], pairs_hi[p], sc, m[0], m[1], m[2], m[3], m[3]);

    for (int sc = 1; sc < 16; sc++) begin
      configure(0, 1, sc, 1, 0, 0, 0, 0, 0, 0);
      c = 0;
      while (!done && c < 2000) begin @(negedge clk); c++; end
      chk(c == 2 * step_ref(sc), $sformatf("R4 step code %0d time to done", sc), c, 2 * step_ref(sc));
    end

    for (int k = 0; k < 58; k++) begin
      int code = (k == 57) ? 63 : k;
      configure(5, 5, 1, 1, 0, 0, 1, code, 0, 0);
      c = 0;
      while (!done && c < 8000) begin @(negedge clk); c++; end
      chk(c == 1 + pause_ref(code), $sformatf("R8 pause code %0d time to done", code), c, 1 + pause_ref(code));
    end

    configure(3, 9, 0, 1, 0, 0, 0, 0, 0, 0);
    repeat (600) @(negedge clk);
    chk(cur_idx == 3 && busy && !done && duty == tbl_m[3], "R10 zero step code holds index", cur_idx, 3);

    gen_en = 0;
    @(negedge clk);
    chk(!busy && !done && duty == 0, "R11 disable mid-run goes idle", duty, 0);
    start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    chk(!busy && !done && duty == 0, "R11 start ignored while disabled", busy, 0);

    configure(2, 4, 1, 1, 0, 0, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    chk(done && !busy && cur_idx == 4 && duty == tbl_m[4], "R9 done holds last entry", cur_idx, 4);
    start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done && cur_idx == 2 && duty == tbl_m[2], "R3 restart from done", cur_idx, 2);

    summary();
    $finish;
  end
endmodule